// File: doc/BRIEF.md
# Interrupt Destination Mask Generator

This block turns one interrupt request's addressing fields into the set of local interrupt units that should receive it. A request carries an 8-bit destination, a bit that chooses physical or logical addressing, a 2-bit shorthand code, the index of the sending unit, and two qualifiers. The first qualifier asks for lowest-priority delivery. The second marks an INIT de-assert command. Each of the `N_UNITS` units supplies a presence flag, an 8-bit physical ID, an 8-bit logical destination and a 4-bit model code. In logical mode the model code picks flat or cluster matching for that unit.

The result is registered. One cycle after a valid request, the block raises a one-cycle strobe and presents three vectors: the target mask, a one-hot single target for lowest-priority delivery, and a mask of units that must copy their physical ID into their arbitration ID. Delivering the vector or signal type to a core is left to the logic around the block.

Top module: `irq_dest_mask`

## Requirements
- R1: In physical mode (`req_logical`=0) with shorthand 0, destination 0xFF selects every present unit.
- R2: In physical mode with shorthand 0, any other destination selects only the lowest-indexed present unit whose physical ID equals the destination. If no present unit matches, the mask is zero.
- R3: In logical mode with shorthand 0, a unit with model code 0xF (flat) is selected when destination AND its logical destination is non-zero.
- R4: In logical mode with shorthand 0, a unit with model code 0x0 (cluster) is selected when destination bits [7:4] equal its logical destination bits [7:4] and bits [3:0] of the two share at least one set bit.
- R5: Shorthand 1 selects only the sender `req_src`. Shorthand 2 selects all present units. Shorthand 3 selects all present units except the sender. With shorthand 1, 2 or 3, the destination and mode bit have no effect.
- R6: With `req_lowpri`=1, `out_pick` is the lowest set bit of the mask, and it is zero if the mask is empty. With `req_lowpri`=0, `out_pick` is zero.
- R7: With `req_init_deassert`=1, the computed mask appears on `out_arb_load`, while `out_mask` and `out_pick` are zero. Otherwise `out_arb_load` is zero.
- R8: A unit whose `unit_present` bit is 0 is never set in any output, broadcast included.
- R9: The outputs appear exactly one cycle after a cycle with `req_valid`=1, qualified by a one-cycle `out_valid`. In any cycle that follows one without a request, `out_valid` and all output vectors are zero.
- R10: After reset, `out_valid` and all output vectors are zero.
- R11: In logical mode, a unit whose model code is neither 0xF nor 0x0 is never selected by addressing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request qualifier |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 0 = physical, 1 = logical addressing |
| req_shorthand | input | 2 | 0 addressed, 1 self, 2 all, 3 all but self |
| req_src | input | SRC_W | Index of the sending unit |
| req_lowpri | input | 1 | Lowest-priority delivery requested |
| req_init_deassert | input | 1 | INIT de-assert: load arbitration IDs instead of delivering |
| unit_present | input | N_UNITS | Unit populated flags |
| unit_phys_id | input | 8*N_UNITS | Physical IDs, unit i at bits [8i+7:8i] |
| unit_log_dest | input | 8*N_UNITS | Logical destinations, unit i at bits [8i+7:8i] |
| unit_model | input | 4*N_UNITS | Model codes, unit i at bits [4i+3:4i] |
| out_valid | output | 1 | Result strobe |
| out_mask | output | N_UNITS | Delivery target mask |
| out_pick | output | N_UNITS | One-hot lowest-priority target |
| out_arb_load | output | N_UNITS | Units that load their arbitration ID |

## Verification
A corrupted match term or shorthand decode shows up as a wrong `out_mask` bit on the strobe that follows the faulty request, so it is visible one cycle after the request. A stale output register would appear as a non-zero vector, or a raised `out_valid`, in the cycle after an idle cycle. The bench therefore checks both the strobe cycle and the idle cycle after it. A wrong lowest-bit isolation or a missing INIT redirection shows up on `out_pick` or `out_arb_load` in that same strobe cycle. Units with duplicate IDs, absent units and an unknown model code are set up on purpose so that the tie-break, presence and matching paths each produce a distinct mask.

// File: rtl/irq_dest_mask.sv
module irq_dest_mask #(
  parameter int N_UNITS = 8,
  parameter int SRC_W   = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [7:0]             req_dest,
  input  logic                   req_logical,
  input  logic [1:0]             req_shorthand,
  input  logic [SRC_W-1:0]       req_src,
  input  logic                   req_lowpri,
  input  logic                   req_init_deassert,
  input  logic [N_UNITS-1:0]     unit_present,
  input  logic [8*N_UNITS-1:0]   unit_phys_id,
  input  logic [8*N_UNITS-1:0]   unit_log_dest,
  input  logic [4*N_UNITS-1:0]   unit_model,
  output logic                   out_valid,
  output logic [N_UNITS-1:0]     out_mask,
  output logic [N_UNITS-1:0]     out_pick,
  output logic [N_UNITS-1:0]     out_arb_load
);

  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;
  localparam logic [7:0] DEST_ALL      = 8'hFF;

  logic [N_UNITS-1:0] phys_hit, log_hit, phys_first, self_bit;
  logic [N_UNITS-1:0] addr_mask, sel_mask, low_bit;

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    logic [7:0] pid, ldst;
    logic [3:0] mdl;
    logic       flat_hit, clus_hit;
    assign pid      = unit_phys_id[8*i +: 8];
    assign ldst     = unit_log_dest[8*i +: 8];
    assign mdl      = unit_model[4*i +: 4];
    assign flat_hit = (mdl == MODEL_FLAT) && |(req_dest & ldst);
    assign clus_hit = (mdl == MODEL_CLUSTER) && (req_dest[7:4] == ldst[7:4])
                      && |(req_dest[3:0] & ldst[3:0]);
    assign phys_hit[i] = unit_present[i] && (pid == req_dest);
    assign log_hit[i]  = unit_present[i] && (flat_hit || clus_hit);
    assign self_bit[i] = unit_present[i] && (req_src == SRC_W'(i));
  end

  assign phys_first = phys_hit & (~phys_hit + N_UNITS'(1));
  assign addr_mask  = req_logical ? log_hit :
                      (req_dest == DEST_ALL) ? unit_present : phys_first;

  always_comb begin
    unique case (req_shorthand)
      2'd0:    sel_mask = addr_mask;
      2'd1:    sel_mask = self_bit;
      2'd2:    sel_mask = unit_present;
      default: sel_mask = unit_present & ~self_bit;
    endcase
  end

  assign low_bit = sel_mask & (~sel_mask + N_UNITS'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_mask     <= '0;
      out_pick     <= '0;
      out_arb_load <= '0;
    end else begin
      out_valid    <= req_valid;
      out_mask     <= '0;
      out_pick     <= '0;
      out_arb_load <= '0;
      if (req_valid) begin
        if (req_init_deassert) begin
          out_arb_load <= sel_mask;
        end else begin
          out_mask <= sel_mask;
          out_pick <= req_lowpri ? low_bit : '0;
        end
      end
    end
  end

endmodule

// File: rtl/irq_dest_mask_chk.sv
module irq_dest_mask_chk #(
  parameter int N_UNITS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_init_deassert,
  input logic               req_lowpri,
  input logic [N_UNITS-1:0] unit_present,
  input logic               out_valid,
  input logic [N_UNITS-1:0] out_mask,
  input logic [N_UNITS-1:0] out_pick,
  input logic [N_UNITS-1:0] out_arb_load
);

  assert_pick_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_pick));

  assert_pick_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pick != '0) |-> (((out_pick - 1'b1) & out_mask) == '0 && (out_pick & out_mask) != '0));

  assert_no_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_lowpri) |=> (out_pick == '0));

  assert_init_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_init_deassert) |=> (out_mask == '0 && out_pick == '0));

  assert_absent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (((out_mask | out_arb_load) & ~$past(unit_present)) == '0));

  assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && out_mask == '0 && out_pick == '0 && out_arb_load == '0));

endmodule

bind irq_dest_mask irq_dest_mask_chk #(.N_UNITS(N_UNITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .req_init_deassert(req_init_deassert), .req_lowpri(req_lowpri),
  .unit_present(unit_present), .out_valid(out_valid), .out_mask(out_mask),
  .out_pick(out_pick), .out_arb_load(out_arb_load)
);

// File: tb/irq_dest_mask_tb_top.sv
`timescale 1ns/1ps
module irq_dest_mask_tb_top;
  localparam int N = 8;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_dest = '0;
  logic req_logical = 1'b0;
  logic [1:0] req_shorthand = '0;
  logic [2:0] req_src = '0;
  logic req_lowpri = 1'b0;
  logic req_init_deassert = 1'b0;
  logic [N-1:0] unit_present = '1;
  logic [8*N-1:0] unit_phys_id, unit_log_dest;
  logic [4*N-1:0] unit_model;
  logic out_valid;
  logic [N-1:0] out_mask, out_pick, out_arb_load;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  irq_dest_mask #(.N_UNITS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
    .req_logical(req_logical), .req_shorthand(req_shorthand), .req_src(req_src),
    .req_lowpri(req_lowpri), .req_init_deassert(req_init_deassert),
    .unit_present(unit_present), .unit_phys_id(unit_phys_id),
    .unit_log_dest(unit_log_dest), .unit_model(unit_model),
    .out_valid(out_valid), .out_mask(out_mask), .out_pick(out_pick),
    .out_arb_load(out_arb_load)
  );

  // Units: IDs 0x10+i except unit 6 = 0x12 (duplicate of unit 2).
  // Models: 0,1,2,6 flat; 3,4,5 cluster; 7 unknown (0x5).
  initial begin
    unit_phys_id  = {8'h17, 8'h12, 8'h15, 8'h14, 8'h13, 8'h12, 8'h11, 8'h10};
    unit_log_dest = {8'hFF, 8'h80, 8'h43, 8'h32, 8'h31, 8'h06, 8'h02, 8'h01};
    unit_model    = {4'h5, 4'hF, 4'h0, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF};
  end

  // {tag, dest, logical, shorthand, lowpri, init, src, exp_mask, exp_pick, exp_arb}
  localparam logic [43:0] VEC [NV] = '{
    {4'd1,  8'hFF, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 8'hFF, 8'h00, 8'h00}, // R1
    {4'd2,  8'h13, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 8'h08, 8'h00, 8'h00}, // R2
    {4'd2,  8'h12, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 8'h04, 8'h00, 8'h00}, // R2 duplicate
    {4'd2,  8'h55, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00}, // R2 no match
    {4'd3,  8'h02, 1'b1, 2'd0, 1'b0, 1'b0, 3'd0, 8'h06, 8'h00, 8'h00}, // R3
    {4'd4,  8'h31, 1'b1, 2'd0, 1'b0, 1'b0, 3'd0, 8'h09, 8'h00, 8'h00}, // R4
    {4'd4,  8'h33, 1'b1, 2'd0, 1'b0, 1'b0, 3'd0, 8'h1F, 8'h00, 8'h00}, // R4
    {4'd6,  8'h80, 1'b1, 2'd0, 1'b1, 1'b0, 3'd0, 8'h40, 8'h40, 8'h00}, // R6
    {4'd5,  8'hFF, 1'b0, 2'd1, 1'b0, 1'b0, 3'd5, 8'h20, 8'h00, 8'h00}, // R5 self
    {4'd5,  8'h55, 1'b1, 2'd2, 1'b0, 1'b0, 3'd3, 8'hFF, 8'h00, 8'h00}, // R5 all
    {4'd5,  8'h13, 1'b0, 2'd3, 1'b1, 1'b0, 3'd0, 8'hFE, 8'h02, 8'h00}, // R5 all-but-self
    {4'd6,  8'h33, 1'b1, 2'd0, 1'b1, 1'b0, 3'd0, 8'h1F, 8'h01, 8'h00}, // R6
    {4'd6,  8'h55, 1'b0, 2'd0, 1'b1, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00}, // R6 empty
    {4'd7,  8'h00, 1'b0, 2'd2, 1'b0, 1'b1, 3'd0, 8'h00, 8'h00, 8'hFF}, // R7
    {4'd7,  8'h13, 1'b0, 2'd0, 1'b1, 1'b1, 3'd0, 8'h00, 8'h00, 8'h08}, // R7
    {4'd11, 8'hFF, 1'b1, 2'd0, 1'b0, 1'b0, 3'd0, 8'h47, 8'h00, 8'h00}, // R11
    {4'd6,  8'h00, 1'b0, 2'd1, 1'b1, 1'b0, 3'd3, 8'h08, 8'h08, 8'h00}  // R6 self
  };

  task automatic chk(input int tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                       input logic lp, input logic ini, input logic [2:0] src);
    @(negedge clk);
    req_valid = 1'b1; req_dest = d; req_logical = lg; req_shorthand = sh;
    req_lowpri = lp; req_init_deassert = ini; req_src = src;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(10, "valid in reset", {7'd0, out_valid}, 8'h00);
    chk(10, "mask in reset", out_mask | out_pick | out_arb_load, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(10, "after reset", {7'd0, out_valid} | out_mask | out_pick | out_arb_load, 8'h00);

    for (int k = 0; k < NV; k++) begin
      logic [43:0] v;
      int tg;
      v = VEC[k];
      tg = int'(v[43:40]);
      issue(v[39:32], v[31], v[30:29], v[28], v[27], v[26:24]);
      chk(9, "strobe", {7'd0, out_valid}, 8'h01);
      chk(tg, $sformatf("row %0d mask", k), out_mask, v[23:16]);
      chk(tg, $sformatf("row %0d pick", k), out_pick, v[15:8]);
      chk(tg, $sformatf("row %0d arb", k), out_arb_load, v[7:0]);
    end

    // R9: idle cycle after a strobe clears everything
    @(negedge clk);
    chk(9, "idle valid", {7'd0, out_valid}, 8'h00);
    chk(9, "idle vectors", out_mask | out_pick | out_arb_load, 8'h00);

    // R8: absent units never selected
    unit_present = 8'h7F;
    issue(8'hFF, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0);
    chk(8, "broadcast absent", out_mask, 8'h7F);
    unit_present = 8'hF7;
    issue(8'h13, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0);
    chk(8, "physical absent", out_mask, 8'h00);
    issue(8'h00, 1'b0, 2'd1, 1'b1, 1'b0, 3'd3);
    chk(8, "self absent", out_mask | out_pick, 8'h00);
    issue(8'h00, 1'b0, 2'd2, 1'b0, 1'b1, 3'd0);
    chk(8, "init absent", out_arb_load, 8'hF7);
    unit_present = 8'hFA;
    issue(8'h00, 1'b0, 2'd3, 1'b1, 1'b0, 3'd1);
    chk(8, "all-but-self absent", out_mask, 8'hF8);
    chk(6, "pick skips absent", out_pick, 8'h08);

    // R9: back-to-back requests
    unit_present = '1;
    @(negedge clk);
    req_valid = 1'b1; req_dest = 8'h10; req_logical = 1'b0; req_shorthand = 2'd0;
    req_lowpri = 1'b0; req_init_deassert = 1'b0;
    @(negedge clk);
    req_dest = 8'h11;
    chk(9, "b2b first", out_mask, 8'h01);
    @(negedge clk);
    req_valid = 1'b0;
    chk(9, "b2b second", out_mask, 8'h02);
    @(negedge clk);
    chk(9, "b2b idle", {7'd0, out_valid}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule